// File: doc/BRIEF.md
# Move-Wide Immediate Unit

This execution unit carries out the three move-wide immediate operations of a 64-bit core. It takes one 32-bit instruction word of the move-wide class and the current contents of the destination register. One clock later it presents the new register value, the destination index, a write-enable and an undefined-instruction flag. The three forms are: an inverted move, which writes the complement of a positioned 16-bit immediate; a zeroing move, which writes the positioned immediate with every other bit cleared; and a keep move, which splices the immediate into one 16-bit slice of the old value and leaves the remaining bits unchanged.

The instruction selects a 32-bit or a 64-bit operand. A 32-bit result always has its upper half cleared. A position that lies outside a 32-bit operand, or the one unused opcode, marks the instruction undefined and suppresses the write. Register index 31 acts as the zero register and is never written. Class decode, register file and fetch sit outside this unit. The unit expects only move-wide words on its input.

Top module: `mw_imm_unit`

## Requirements
- R1: Instruction fields: bit 31 = wide (1 selects 64-bit), bits 30:29 = opcode, bits 22:21 = halfword position hw, bits 20:5 = 16-bit immediate, bits 4:0 = destination index. Opcode 2 (zeroing move) yields the immediate shifted left by 16*hw, with all other bits zero.
- R2: Opcode 0 (inverted move) yields the bitwise complement of the immediate shifted left by 16*hw.
- R3: Opcode 3 (keep move) yields the old register value with bits [16*hw+15 : 16*hw] replaced by the immediate and every other bit taken from the old value.
- R4: The shift amount is exactly 16*hw for each hw in 0..3, so the immediate lands in the slice of that index.
- R5: With wide = 0 and hw of 2 or 3, undef_o is 1, wr_en_o is 0 and result_o is 0.
- R6: Opcode 1 is undefined in both widths: undef_o is 1, wr_en_o is 0 and result_o is 0.
- R7: With wide = 0, result_o[63:32] is zero for every defined opcode, including the keep move.
- R8: A defined instruction with destination index 31 gives wr_en_o = 0 and undef_o = 0, and result_o still carries the computed value.
- R9: Outputs are registered with one cycle of latency: the values for an instruction presented with valid_i = 1 at a rising edge appear after that edge, and rd_o echoes bits 4:0. A cycle with valid_i = 0 drives wr_en_o and undef_o to 0 and holds result_o and rd_o.
- R10: While rst_ni is low, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | An instruction is presented this cycle |
| insn_i | input | 32 | Move-wide instruction word |
| old_val_i | input | 64 | Current value of the destination register |
| result_o | output | 64 | New register value |
| rd_o | output | 5 | Destination register index |
| wr_en_o | output | 1 | Write the result to the register file |
| undef_o | output | 1 | Instruction is undefined |

## Verification
Two pairs of functions can act on the same instruction. The width limit and the keep merge meet when a 32-bit keep move with a legal position receives an old value whose upper half is all ones. The upper half must come out as zero, and the merge must hold everywhere else. The undefined checks and the zero-register rule meet when an undefined word also names register 31. The sweep covers every combination of width, opcode, position and destination index {0, 5, 31} with several immediates and old values. It judges each output against an arithmetic model, and for an undefined word it requires undef_o high, wr_en_o low and a zero result.

// File: rtl/mw_pkg.sv
package mw_pkg;
  localparam int unsigned INSN_W = 32;
  localparam int unsigned IMM_W  = 16;
  localparam int unsigned RIDX_W = 5;
  localparam int unsigned HW_W   = 2;

  typedef enum logic [1:0] {
    MW_INV  = 2'd0,
    MW_RSV  = 2'd1,
    MW_ZERO = 2'd2,
    MW_KEEP = 2'd3
  } mw_op_e;

  typedef struct packed {
    logic              wide;
    mw_op_e            op;
    logic [HW_W-1:0]   hw;
    logic [IMM_W-1:0]  imm;
    logic [RIDX_W-1:0] rd;
  } mw_fields_t;
endpackage

// File: rtl/mw_decode.sv
module mw_decode
  import mw_pkg::*;
#(
  parameter int unsigned XLEN     = 64,
  parameter int unsigned ZERO_REG = 31
) (
  input  logic [INSN_W-1:0] insn_i,
  output mw_fields_t        fld_o,
  output logic              illegal_o,
  output logic              zero_dst_o
);
  localparam int unsigned NARROW_LANES = (XLEN / 2) / IMM_W;

  always_comb begin
    fld_o.wide = insn_i[31];
    fld_o.op   = mw_op_e'(insn_i[30:29]);
    fld_o.hw   = insn_i[22:21];
    fld_o.imm  = insn_i[20:5];
    fld_o.rd   = insn_i[4:0];
  end

  logic narrow_oob;
  assign narrow_oob = !fld_o.wide && (int'(fld_o.hw) >= NARROW_LANES);
  assign illegal_o  = (fld_o.op == MW_RSV) || narrow_oob;
  assign zero_dst_o = (int'(fld_o.rd) == ZERO_REG);
endmodule

// File: rtl/mw_lane_merge.sv
module mw_lane_merge
  import mw_pkg::*;
#(
  parameter int unsigned XLEN = 64
) (
  input  mw_fields_t      fld_i,
  input  logic [XLEN-1:0] old_i,
  output logic [XLEN-1:0] val_o
);
  localparam int unsigned LANES        = XLEN / IMM_W;
  localparam int unsigned NARROW_LANES = (XLEN / 2) / IMM_W;

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    logic             hit;
    logic [IMM_W-1:0] lane;
    assign hit = (fld_i.hw == HW_W'(k));

    always_comb begin
      unique case (fld_i.op)
        MW_INV:  lane = hit ? ~fld_i.imm : '1;
        MW_ZERO: lane = hit ?  fld_i.imm : '0;
        MW_KEEP: lane = hit ?  fld_i.imm : old_i[k*IMM_W +: IMM_W];
        default: lane = '0;
      endcase
    end

    if (k >= NARROW_LANES) begin : g_upper
      // upper half cleared for 32-bit operands
      assign val_o[k*IMM_W +: IMM_W] = fld_i.wide ? lane : '0;
    end else begin : g_lower
      assign val_o[k*IMM_W +: IMM_W] = lane;
    end
  end
endmodule

// File: rtl/mw_imm_unit.sv
module mw_imm_unit
  import mw_pkg::*;
#(
  parameter int unsigned XLEN     = 64,
  parameter int unsigned ZERO_REG = 31
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [31:0]       insn_i,
  input  logic [XLEN-1:0]   old_val_i,
  output logic [XLEN-1:0]   result_o,
  output logic [4:0]        rd_o,
  output logic              wr_en_o,
  output logic              undef_o
);
  localparam int unsigned HALF = XLEN / 2;

  mw_fields_t      fld;
  logic            illegal, zero_dst;
  logic [XLEN-1:0] merged;

  mw_decode #(.XLEN(XLEN), .ZERO_REG(ZERO_REG)) u_decode (
    .insn_i     (insn_i),
    .fld_o      (fld),
    .illegal_o  (illegal),
    .zero_dst_o (zero_dst)
  );

  mw_lane_merge #(.XLEN(XLEN)) u_merge (
    .fld_i (fld),
    .old_i (old_val_i),
    .val_o (merged)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      result_o <= '0;
      rd_o     <= '0;
      wr_en_o  <= 1'b0;
      undef_o  <= 1'b0;
    end else if (valid_i) begin
      result_o <= illegal ? '0 : merged;
      rd_o     <= fld.rd;
      wr_en_o  <= !illegal && !zero_dst;
      undef_o  <= illegal;
    end else begin
      wr_en_o  <= 1'b0;
      undef_o  <= 1'b0;
    end
  end

  // R5
  undef_no_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    undef_o |-> (!wr_en_o && result_o == '0));

  // R8
  zero_reg_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> (int'(rd_o) != ZERO_REG));

  // R7
  narrow_upper_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !insn_i[31]) |=> (result_o[XLEN-1:HALF] == '0));

  // R3
  keep_upper_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && insn_i[31] && insn_i[30:29] == 2'd3 && insn_i[22:21] == 2'd0)
    |=> (result_o[XLEN-1:IMM_W] == $past(old_val_i[XLEN-1:IMM_W])));

  // R1
  zero_move_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && insn_i[31] && insn_i[30:29] == 2'd2 && insn_i[22:21] == 2'd0)
    |=> (result_o == XLEN'($past(insn_i[20:5]))));

  // R9
  idle_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> (!wr_en_o && !undef_o && $stable(result_o) && $stable(rd_o)));
endmodule

// File: tb/mw_imm_unit_bench.sv
module mw_imm_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0;
  logic [31:0] insn = '0;
  logic [63:0] old_val = '0;
  logic [63:0] result;
  logic [4:0]  rd;
  logic        wr_en, undef;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  mw_imm_unit u_mw_imm_unit (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .insn_i(insn),
    .old_val_i(old_val), .result_o(result), .rd_o(rd),
    .wr_en_o(wr_en), .undef_o(undef)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] enc(input bit sf, input int op, input int hw, input logic [15:0] imm, input int r);
    return {sf, 2'(op), 6'b100101, 2'(hw), imm, 5'(r)};
  endfunction

  initial begin
    logic [15:0] imms [3] = '{16'h0000, 16'hFFFF, 16'hA5C3};
    logic [63:0] olds [2] = '{64'hFFFF_FFFF_FFFF_FFFF, 64'h0123_4567_89AB_CDEF};
    int          rds  [3] = '{0, 5, 31};
    #1;
    // R10
    check(result == 0 && wr_en == 0 && undef == 0 && rd == 0, "R10", {result[59:0], wr_en, undef, 2'b0}, 64'h0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    for (int sf = 0; sf < 2; sf++)
      for (int op = 0; op < 4; op++)
        for (int hw = 0; hw < 4; hw++)
          for (int ii = 0; ii < 3; ii++)
            for (int oi = 0; oi < 2; oi++)
              for (int ri = 0; ri < 3; ri++) begin
                logic [63:0] pos, ev;
                bit          e_undef, e_wr;
                string       tag;
                pos     = {48'h0, imms[ii]} << (16 * hw);
                e_undef = (op == 1) || (sf == 0 && hw >= 2);
                case (op)
                  0: ev = ~pos;
                  2: ev = pos;
                  3: ev = (olds[oi] & ~(64'hFFFF << (16 * hw))) | pos;
                  default: ev = 64'h0;
                endcase
                if (sf == 0) ev[63:32] = 32'h0;
                if (e_undef) ev = 64'h0;
                e_wr = !e_undef && rds[ri] != 31;
                if (op == 1) tag = "R6";
                else if (e_undef) tag = "R5";
                else if (sf == 0) tag = "R7";
                else if (op == 0) tag = "R2";
                else if (op == 3) tag = "R3";
                else if (hw != 0) tag = "R4";
                else tag = "R1";
                insn = enc(sf[0], op, hw, imms[ii], rds[ri]);
                old_val = olds[oi];
                valid = 1'b1;
                @(negedge clk);
                check(result == ev, tag, result, ev);
                check(undef == e_undef, tag, {63'h0, undef}, {63'h0, e_undef});
                // R8 write enable incl. zero register
                check(wr_en == e_wr, (rds[ri] == 31) ? "R8" : tag, {63'h0, wr_en}, {63'h0, e_wr});
                // R9 destination echo
                check(rd == 5'(rds[ri]), "R9", {59'h0, rd}, 64'(rds[ri]));
              end
    // R9 idle cycle after a legal write
    insn = enc(1'b1, 2, 1, 16'h1234, 7); valid = 1'b1;
    @(negedge clk);
    valid = 1'b0; insn = enc(1'b1, 0, 3, 16'hFFFF, 9);
    @(negedge clk);
    check(wr_en == 0 && undef == 0, "R9", {62'h0, wr_en, undef}, 64'h0);
    check(result == 64'h0000_0000_1234_0000, "R9", result, 64'h0000_0000_1234_0000);
    check(rd == 5'd7, "R9", {59'h0, rd}, 64'd7);
    // R10 reset mid-run
    insn = enc(1'b1, 0, 0, 16'h0, 3); valid = 1'b1;
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check(result == 0 && wr_en == 0 && rd == 0, "R10", result, 64'h0);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #200000;
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule